// File: doc/BRIEF.md
# SPI Byte Shifter with Movable MISO Sample Point

This block is the serial engine of an SD-card style SPI master running in mode 0. It takes one byte at a time through a request/acknowledge port, generates SCK from the system clock with a programmable number of system clocks per bit, shifts the byte out on MOSI most significant bit first, and shifts a byte in from MISO at the same time. Chip select, command framing and the multi-lane bus modes are handled elsewhere.

The MISO capture point can be moved relative to the rising SCK edge. When the divider is large, the line is taken on the edge. When the divider is below a threshold, the line is taken roughly 30% of a bit cell before the edge, which gives a slow card more margin on its trailing data. An override replaces that automatic choice, and a separate control adds one more input register stage. Every setting is captured when a byte is accepted, so a change on the configuration inputs never disturbs a byte in flight.

Top module: `sd_spi_adapt`

## Requirements
- R1: After reset, and whenever no byte is in flight, sck_o is 0, mosi_o is 1, and busy_o, done_o and ack_o are 0.
- R2: The bit cell length P is div_i system clocks, raised to 8 when div_i is below 8. With H = floor(P/2), sck_o is 0 in cycles 0..H-1 of each cell and 1 in cycles H..P-1. Cycle 0 of the first cell is the cycle right after the accepting clock edge, and cycle 0 of every later cell follows a falling edge.
- R3: At the start of a byte, SCK is held low and the cell counter restarts, so the first rising edge of sck_o always comes exactly H cycles after cycle 0 of the first cell.
- R4: MOSI carries tx_byte_i MSB first. Bit k is valid for the whole of cell k and changes only at cell boundaries, which are the falling edges of SCK.
- R5: In on-edge mode, received bit k is the miso_i level during cycle H of cell k.
- R6: In early mode, received bit k is the miso_i level during cycle H-F of cell k, where F = max(1, floor(3P/10)).
- R7: Without an override, early mode is chosen when P < thresh_i and on-edge mode otherwise.
- R8: With ovr_en_i = 1, ovr_early_i picks the mode: 1 gives early and 0 gives on-edge, whatever P and thresh_i are.
- R9: extra_stage_i = 1 adds one register stage on MISO, which moves the observed cycle one clock earlier (H-1 in on-edge mode, H-F-1 in early mode).
- R10: done_o is high for exactly one cycle, in cycle 8P after the accepting edge. In that cycle rx_byte_o holds the received byte (first received bit in bit 7), busy_o is 0 and sck_o is 0.
- R11: A request is accepted only while busy_o is 0. ack_o pulses in cycle 0 of the first cell, and a request held during a byte is ignored.
- R12: Changes to div_i, thresh_i, the override inputs, extra_stage_i or tx_byte_i while a byte is in flight do not change its timing, its MOSI data or its capture point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | System clocks per SPI bit (minimum 8 applied) |
| thresh_i | input | DIV_W | Divider below which early sampling is chosen |
| ovr_en_i | input | 1 | Replace the automatic sample mode |
| ovr_early_i | input | 1 | Forced mode: 1 early, 0 on-edge |
| extra_stage_i | input | 1 | Add one MISO register stage |
| req_i | input | 1 | Request to transfer one byte |
| tx_byte_i | input | DATA_W | Byte to send |
| ack_o | output | 1 | One-cycle pulse when a request is taken |
| busy_o | output | 1 | Byte in flight |
| done_o | output | 1 | One-cycle pulse with the received byte |
| rx_byte_o | output | DATA_W | Received byte, held until the next done |
| sck_o | output | 1 | SPI clock, idle low |
| mosi_o | output | 1 | Serial data out, idle high |
| miso_i | input | 1 | Serial data in |

## Verification
The card model drives the true data bit on MISO only in the single cycle where the capture should happen and drives the inverted bit in every other cycle. A capture point off by even one clock therefore returns the complement of the expected byte. This exposes a wrong 3/10 offset, a wrong comparison at the threshold boundary (P equal to the threshold must stay on-edge), an override that is ignored, and an extra stage that is applied in the wrong direction. Dividers below 8 and odd dividers are checked against the full SCK shape, because a missing clamp or a half-cell rounded the wrong way would move the edges. A run that changes every configuration input and keeps a request asserted in the middle of a byte would show a latching fault as shifted edges, a second acknowledge, or a corrupted byte.

// File: rtl/sd_spi_adapt_pkg.sv
package sd_spi_adapt_pkg;
  typedef enum logic {SAMP_EDGE = 1'b0, SAMP_EARLY = 1'b1} samp_mode_e;
  localparam int OFF_NUM = 3;
  localparam int OFF_DEN = 10;
endpackage

// File: rtl/sd_spi_cfg.sv
module sd_spi_cfg
  import sd_spi_adapt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] thresh_i,
  input  logic             ovr_en_i,
  input  logic             ovr_early_i,
  output logic [DIV_W-1:0] period_o,
  output logic [DIV_W-1:0] half_o,
  output logic [DIV_W-1:0] cap_o
);
  localparam int PW = DIV_W + 2;

  logic [PW-1:0] per_w, off_w, sub_w;
  samp_mode_e    mode;

  always_comb begin
    per_w = (div_i < DIV_W'(MIN_DIV)) ? PW'(MIN_DIV) : PW'(div_i);
    off_w = (per_w * PW'(OFF_NUM)) / PW'(OFF_DEN);
    if (off_w == '0) off_w = PW'(1);
    if (ovr_en_i) mode = ovr_early_i ? SAMP_EARLY : SAMP_EDGE;
    else          mode = (per_w < PW'(thresh_i)) ? SAMP_EARLY : SAMP_EDGE;
    sub_w    = (mode == SAMP_EARLY) ? off_w : '0;
    period_o = DIV_W'(per_w);
    half_o   = DIV_W'(per_w >> 1);
    // one cycle later than the observed pin cycle: first MISO stage
    cap_o    = DIV_W'((per_w >> 1) - sub_w + PW'(1));
  end
endmodule

// File: rtl/sd_spi_bitclk.sv
module sd_spi_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic [DIV_W-1:0] half_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             cell_end_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] cnt_q;

  assign cell_end_o = run_i && (cnt_q == period_i - DIV_W'(1));
  assign sck_o      = run_i && (cnt_q >= half_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (start_i)    cnt_q <= '0;
    else if (cell_end_o) cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sd_spi_miso_pipe.sv
module sd_spi_miso_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miso_i,
  input  logic extra_i,
  output logic bit_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b11;
    else         stg_q <= {stg_q[0], miso_i};
  end

  assign bit_o = extra_i ? stg_q[1] : stg_q[0];
endmodule

// File: rtl/sd_spi_adapt.sv
module sd_spi_adapt #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DIV_W-1:0]  thresh_i,
  input  logic              ovr_en_i,
  input  logic              ovr_early_i,
  input  logic              extra_stage_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  logic [DIV_W-1:0]  cfg_period, cfg_half, cfg_cap;
  logic [DIV_W-1:0]  period_q, half_q, cap_q, cnt;
  logic              busy_q, done_q, ack_q, mosi_q, extra_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q;
  logic              start, cell_end, miso_bit;

  assign start = req_i && !busy_q;

  sd_spi_cfg #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_cfg (
    .div_i(div_i), .thresh_i(thresh_i), .ovr_en_i(ovr_en_i), .ovr_early_i(ovr_early_i),
    .period_o(cfg_period), .half_o(cfg_half), .cap_o(cfg_cap)
  );

  sd_spi_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .run_i(busy_q),
    .period_i(period_q), .half_i(half_q),
    .cnt_o(cnt), .cell_end_o(cell_end), .sck_o(sck_o)
  );

  sd_spi_miso_pipe u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .miso_i(miso_i), .extra_i(extra_q), .bit_o(miso_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
      mosi_q   <= 1'b1;
      extra_q  <= 1'b0;
      bit_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_q     <= '0;
      period_q <= DIV_W'(MIN_DIV);
      half_q   <= DIV_W'(MIN_DIV / 2);
      cap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      if (start) begin
        // settings frozen for the whole byte
        busy_q   <= 1'b1;
        ack_q    <= 1'b1;
        bit_q    <= '0;
        mosi_q   <= tx_byte_i[DATA_W-1];
        tx_sh    <= {tx_byte_i[DATA_W-2:0], 1'b0};
        period_q <= cfg_period;
        half_q   <= cfg_half;
        cap_q    <= cfg_cap;
        extra_q  <= extra_stage_i;
      end else if (busy_q) begin
        if (cnt == cap_q) rx_sh <= {rx_sh[DATA_W-2:0], miso_bit};
        if (cell_end) begin
          if (bit_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= rx_sh;
            mosi_q <= 1'b1;
          end else begin
            bit_q  <= bit_q + BW'(1);
            mosi_q <= tx_sh[DATA_W-1];
            tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign ack_o     = ack_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_q;
  assign mosi_o    = mosi_q;
endmodule

// File: rtl/sd_spi_adapt_chk.sv
module sd_spi_adapt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic sck_o,
  input logic mosi_o,
  input logic done_o,
  input logic ack_o
);
  p_sck_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);

  p_mosi_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> mosi_o);

  p_mosi_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$fell(sck_o)) |-> $stable(mosi_o));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_ack_idle_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (busy_o && !$past(busy_o)));
endmodule

bind sd_spi_adapt sd_spi_adapt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .sck_o(sck_o),
  .mosi_o(mosi_o), .done_o(done_o), .ack_o(ack_o)
);

// File: tb/sd_spi_adapt_tb_top.sv
module sd_spi_adapt_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = 8'd20, thresh_i = 8'd16;
  logic       ovr_en_i = 1'b0, ovr_early_i = 1'b0, extra_stage_i = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       ack_o, busy_o, done_o, sck_o, mosi_o;
  logic [7:0] rx_byte_o;
  logic       miso_i = 1'b1;

  sd_spi_adapt dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .thresh_i(thresh_i),
    .ovr_en_i(ovr_en_i), .ovr_early_i(ovr_early_i), .extra_stage_i(extra_stage_i),
    .req_i(req_i), .tx_byte_i(tx_byte_i), .ack_o(ack_o), .busy_o(busy_o),
    .done_o(done_o), .rx_byte_o(rx_byte_o), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0, start_cyc = 0;
  bit active = 0, finished = 0;
  int per = 8, hlf = 4, tgt = 4;
  logic [7:0] dpat = 8'h00, mosi_acc = 8'h00, got_rx = 8'h00;
  int sck_bad, mosi_bad, busy_bad, ack_bad, done_bad, first_rise;
  logic done_at, done_after, idle_ok, prev_mosi;

  always @(posedge clk_i) cyc <= cyc + 1;

  // card model and monitor, 1 ns after the falling clock edge
  always @(negedge clk_i) begin
    #1;
    if (active) begin
      int rel, k, m;
      rel = cyc - start_cyc;
      if (rel < 8 * per) begin
        k = rel / per;
        m = rel % per;
        miso_i = (m == tgt) ? dpat[7-k] : ~dpat[7-k];
        if (sck_o !== (m >= hlf)) sck_bad++;
        if (sck_o && first_rise < 0) first_rise = rel;
        if (busy_o !== 1'b1) busy_bad++;
        if (m == hlf) mosi_acc = {mosi_acc[6:0], mosi_o};
        if (m != 0 && mosi_o !== prev_mosi) mosi_bad++;
        prev_mosi = mosi_o;
        if (done_o) done_bad++;
        if (rel > 0 && ack_o) ack_bad++;
      end else begin
        miso_i = 1'b1;
      end
      if (rel == 8 * per) begin
        done_at = done_o;
        got_rx  = rx_byte_o;
        idle_ok = !busy_o && !sck_o && mosi_o;
      end
      if (rel == 8 * per + 1) done_after = done_o;
    end else begin
      miso_i = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run(input int div, input int thr, input bit oe, input bit oel, input bit ex,
                     input logic [7:0] tx, input logic [7:0] dd, input bit disturb, input string rq);
    int off;
    bit early;
    per = (div < 8) ? 8 : div;
    hlf = per / 2;
    off = (per * 3) / 10;
    if (off < 1) off = 1;
    early = oe ? oel : (per < thr);
    tgt = hlf - (early ? off : 0) - (ex ? 1 : 0);
    dpat = dd;
    sck_bad = 0; mosi_bad = 0; busy_bad = 0; ack_bad = 0; done_bad = 0; first_rise = -1;
    done_at = 0; done_after = 1; idle_ok = 0; got_rx = 8'h00;
    @(negedge clk_i);
    div_i = 8'(div); thresh_i = 8'(thr); ovr_en_i = oe; ovr_early_i = oel;
    extra_stage_i = ex; tx_byte_i = tx; req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_cyc = cyc;
    active = 1;
    chk(ack_o === 1'b1, "R11", "ack in first cycle", int'(ack_o), 1);
    if (disturb) begin
      tx_byte_i = ~tx; div_i = 8'(div + 7); thresh_i = 8'(per + 40);
      ovr_en_i = 1'b1; ovr_early_i = ~early; extra_stage_i = ~ex;
      repeat (4 * per) @(negedge clk_i);
      req_i = 1'b0;
      repeat (4 * per + 2) @(negedge clk_i);
    end else begin
      req_i = 1'b0;
      repeat (8 * per + 2) @(negedge clk_i);
    end
    active = 0;
    chk(sck_bad == 0, "R2", "sck shape errors", sck_bad, 0);
    chk(first_rise == hlf, "R3", "first rising cycle", first_rise, hlf);
    chk(mosi_acc == tx && mosi_bad == 0, "R4", "mosi byte", int'(mosi_acc), int'(tx));
    chk(got_rx == dd, rq, "received byte", int'(got_rx), int'(dd));
    chk(done_at && !done_after && done_bad == 0 && idle_ok && busy_bad == 0, "R10",
        "done pulse/idle", {done_at, done_after, idle_ok}, 3'b101);
    chk(ack_bad == 0, "R11", "extra ack while busy", ack_bad, 0);
  endtask

  task automatic reset_test();
    @(negedge clk_i);
    chk(!sck_o && mosi_o && !busy_o && !done_o && !ack_o, "R1", "state in reset",
        {sck_o, mosi_o, busy_o, done_o, ack_o}, 5'b01000);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!sck_o && mosi_o && !busy_o && !done_o && !ack_o, "R1", "idle after reset",
        {sck_o, mosi_o, busy_o, done_o, ack_o}, 5'b01000);
  endtask

  initial begin
    reset_test();
    run(20, 16, 0, 0, 0, 8'hA5, 8'h3C, 0, "R5");   // on-edge, cycle 10
    run(10, 16, 0, 0, 0, 8'h5A, 8'hC3, 0, "R6");   // early, F=3, cycle 2
    run(3,  16, 0, 0, 0, 8'h81, 8'h7E, 0, "R2");   // clamp to 8, cycle 2
    run(9,  16, 0, 0, 0, 8'h0F, 8'hB2, 0, "R6");   // odd, H=4 F=2
    run(16, 16, 0, 0, 0, 8'hF0, 8'h69, 0, "R7");   // P == thresh: on-edge
    run(15, 16, 0, 0, 0, 8'h33, 8'h96, 0, "R7");   // P < thresh: early
    run(10, 16, 1, 0, 0, 8'hCC, 8'h1E, 0, "R8");   // forced on-edge
    run(20, 16, 1, 1, 0, 8'h55, 8'hE1, 0, "R8");   // forced early, F=6
    run(20, 16, 0, 0, 1, 8'hAA, 8'h47, 0, "R9");   // extra stage, cycle 9
    run(8,  16, 0, 0, 1, 8'h01, 8'hD8, 0, "R9");   // early plus extra, cycle 1
    run(12, 16, 0, 0, 0, 8'h96, 8'h2D, 1, "R12");  // inputs disturbed mid-byte
    run(12, 16, 0, 0, 0, 8'h6B, 8'hF4, 0, "R12");  // next byte uses new settings
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule